// File: doc/BRIEF.md
# Hardware Loop Register Bank

This block holds the state behind zero-overhead loops in a small in-order processor. It has several loop register sets. Each set stores a loop start address, a loop end address and an iteration counter. A loop controller reads every set through flattened read ports. It uses those values to redirect fetch and to decide when a loop finishes.

The block has two halves. The first is a combinational decoder. It takes a loop-setup function code, the current PC, a source register value and two immediates, and produces a write-enable vector and the three data words to write. The second is the register bank. It accepts a write port (three data words, a three-bit enable and a set index) plus a decrement request aimed at one set. The surrounding pipeline normally routes the decoder outputs, possibly delayed by a stage, into the write port.

Top module: `loop_reg_bank`

## Requirements
- R1: While `rst_n` is low, every start, end and counter register is held at zero.
- R2: On a clock edge, `wr_en` bit 0 loads `wr_start`, bit 1 loads `wr_end` and bit 2 loads `wr_cnt` into the set chosen by `wr_set`. Any combination of the three bits may be set together. Other sets and other fields keep their values.
- R3: A write whose `wr_set` is not below `NSETS` changes no register.
- R4: For a valid operation, code 3'b000 gives `dec_we`=3'b001 with `dec_start` = PC + sign-extended `op_imm_i`. Code 3'b001 gives `dec_we`=3'b010 with `dec_end` = PC + sign-extended `op_imm_i`.
- R5: Code 3'b010 gives `dec_we`=3'b100 with `dec_cnt` = `op_rs1`. Code 3'b011 gives `dec_we`=3'b100 with `dec_cnt` = sign-extended `op_imm_i`.
- R6: Code 3'b100 gives `dec_we`=3'b111 with `dec_cnt` = `op_rs1`, `dec_start` = PC + 4 and `dec_end` = PC + sign-extended `op_imm_i`.
- R7: Code 3'b101 gives `dec_we`=3'b111 with `dec_cnt` = sign-extended `op_imm_i`, `dec_start` = PC + 4 and `dec_end` = PC + (zero-extended `op_imm_z` shifted left by one).
- R8: Codes 3'b110 and 3'b111 give `dec_we`=3'b000. Any code with `op_valid` low also gives 3'b000.
- R9: When `dec_req` is high and `stall` is low, the counter of set `dec_sel` decreases by one on the clock edge. The subtraction wraps modulo 2^DW, so 0 becomes all ones.
- R10: When `stall` is high, `dec_req` changes no counter.
- R11: If a counter write and a decrement target the same set in the same cycle, the counter takes `wr_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Loop-setup operation present |
| op_func | input | 3 | Loop-setup function code |
| op_pc | input | DW | PC of the operation |
| op_rs1 | input | DW | Source register value |
| op_imm_i | input | IMMW | Signed immediate |
| op_imm_z | input | IMMW | Unsigned immediate, halfword offset |
| dec_we | output | 3 | Decoded enables {counter, end, start} |
| dec_start | output | DW | Decoded start address |
| dec_end | output | DW | Decoded end address |
| dec_cnt | output | DW | Decoded counter value |
| wr_en | input | 3 | Write enables {counter, end, start} |
| wr_set | input | SELW | Set index for the write |
| wr_start | input | DW | Start address to write |
| wr_end | input | DW | End address to write |
| wr_cnt | input | DW | Counter value to write |
| dec_req | input | 1 | Decrement request |
| dec_sel | input | SELW | Set index for the decrement |
| stall | input | 1 | Decode stall, blocks decrement |
| rd_start | output | NSETS*DW | Start address of each set, set g at bits g*DW |
| rd_end | output | NSETS*DW | End address of each set |
| rd_cnt | output | NSETS*DW | Counter of each set |

## Verification
The clocked assertions assume that the write and decrement inputs are stable around each rising edge. Each assertion compares a register's next value with the inputs it sampled in the cycle before. The bench therefore changes every input only on the falling edge and reads the register outputs one falling edge after the rising edge that captured them. Decoder checks are made a short delay after the operation inputs settle, because that path holds no state. The out-of-range write uses index 3, which the default of two sets never decodes.

// File: rtl/loop_reg_bank.sv
module loop_reg_bank #(
  parameter int NSETS = 2,
  parameter int DW    = 32,
  parameter int IMMW  = 12,
  parameter int SELW  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [2:0]            op_func,
  input  logic [DW-1:0]         op_pc,
  input  logic [DW-1:0]         op_rs1,
  input  logic [IMMW-1:0]       op_imm_i,
  input  logic [IMMW-1:0]       op_imm_z,
  output logic [2:0]            dec_we,
  output logic [DW-1:0]         dec_start,
  output logic [DW-1:0]         dec_end,
  output logic [DW-1:0]         dec_cnt,
  input  logic [2:0]            wr_en,
  input  logic [SELW-1:0]       wr_set,
  input  logic [DW-1:0]         wr_start,
  input  logic [DW-1:0]         wr_end,
  input  logic [DW-1:0]         wr_cnt,
  input  logic                  dec_req,
  input  logic [SELW-1:0]       dec_sel,
  input  logic                  stall,
  output logic [NSETS*DW-1:0]   rd_start,
  output logic [NSETS*DW-1:0]   rd_end,
  output logic [NSETS*DW-1:0]   rd_cnt
);

  localparam logic [DW-1:0] INSN_BYTES = DW'(4);

  logic [DW-1:0] imm_s, imm_h, pc_next, pc_off;

  assign imm_s   = {{(DW-IMMW){op_imm_i[IMMW-1]}}, op_imm_i};
  assign imm_h   = {{(DW-IMMW-1){1'b0}}, op_imm_z, 1'b0};
  assign pc_next = op_pc + INSN_BYTES;
  assign pc_off  = op_pc + imm_s;

  always_comb begin
    dec_we    = 3'b000;
    dec_start = pc_next;
    dec_end   = pc_off;
    dec_cnt   = op_rs1;
    case (op_func)
      3'b000: begin dec_we = 3'b001; dec_start = pc_off; end
      3'b001: dec_we = 3'b010;
      3'b010: dec_we = 3'b100;
      3'b011: begin dec_we = 3'b100; dec_cnt = imm_s; end
      3'b100: dec_we = 3'b111;
      3'b101: begin dec_we = 3'b111; dec_cnt = imm_s; dec_end = op_pc + imm_h; end
      default: dec_we = 3'b000;
    endcase
    if (!op_valid) dec_we = 3'b000;
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    logic [DW-1:0] start_q, end_q, cnt_q;
    logic          hit_w, hit_d;

    assign hit_w = (wr_set == SELW'(g));
    assign hit_d = dec_req && !stall && (dec_sel == SELW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        start_q <= '0;
        end_q   <= '0;
        cnt_q   <= '0;
      end else begin
        if (hit_w && wr_en[0]) start_q <= wr_start;
        if (hit_w && wr_en[1]) end_q   <= wr_end;
        if (hit_w && wr_en[2]) cnt_q   <= wr_cnt;
        else if (hit_d)        cnt_q   <= cnt_q - 1'b1;
      end
    end

    assign rd_start[g*DW +: DW] = start_q;
    assign rd_end[g*DW +: DW]   = end_q;
    assign rd_cnt[g*DW +: DW]   = cnt_q;

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[0] && wr_set == SELW'(g)) |=> rd_start[g*DW +: DW] == $past(wr_start));
    // R2
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en[1] && wr_set == SELW'(g)) |=> $stable(rd_end[g*DW +: DW]));
    // R9
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_req && !stall && dec_sel == SELW'(g) && !(wr_en[2] && wr_set == SELW'(g)))
      |=> rd_cnt[g*DW +: DW] == $past(rd_cnt[g*DW +: DW]) - 1'b1);
    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !(wr_en[2] && wr_set == SELW'(g))) |=> $stable(rd_cnt[g*DW +: DW]));
    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en[2] && wr_set == SELW'(g)) |=> rd_cnt[g*DW +: DW] == $past(wr_cnt));
  end

  // R8
  idle_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_func[2:1] == 2'b11) |-> dec_we == 3'b000);

endmodule

// File: tb/sim_loop_reg_bank.sv
`timescale 1ns/1ps
module sim_loop_reg_bank;
  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0;
  logic [2:0]  op_func = 0;
  logic [31:0] op_pc = 0, op_rs1 = 0;
  logic [11:0] op_imm_i = 0, op_imm_z = 0;
  logic [2:0]  dec_we;
  logic [31:0] dec_start, dec_end, dec_cnt;
  logic [2:0]  wr_en = 0;
  logic [1:0]  wr_set = 0, dec_sel = 0;
  logic [31:0] wr_start = 0, wr_end = 0, wr_cnt = 0;
  logic        dec_req = 0, stall = 0;
  logic [63:0] rd_start, rd_end, rd_cnt;
  int          tests = 0, fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  loop_reg_bank u0 (.*);

  typedef struct packed {
    logic [2:0]  f;
    logic [31:0] pc, rs1;
    logic [11:0] ii, iz;
    logic [2:0]  we;
    logic [31:0] s, e, c;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b000, 32'h1000, 32'd0,  12'h010, 12'h000, 3'b001, 32'h1010, 32'h0,    32'h0},
    '{3'b001, 32'h2000, 32'd0,  12'hFFC, 12'h000, 3'b010, 32'h0,    32'h1FFC, 32'h0},
    '{3'b010, 32'h0,    32'h55, 12'h000, 12'h000, 3'b100, 32'h0,    32'h0,    32'h55},
    '{3'b011, 32'h0,    32'd0,  12'h800, 12'h000, 3'b100, 32'h0,    32'h0,    32'hFFFFF800},
    '{3'b100, 32'h100,  32'd9,  12'h040, 12'h000, 3'b111, 32'h104,  32'h140,  32'h9},
    '{3'b101, 32'h200,  32'd0,  12'h005, 12'h030, 3'b111, 32'h204,  32'h260,  32'h5},
    '{3'b110, 32'h300,  32'd4,  12'h004, 12'h004, 3'b000, 32'h0,    32'h0,    32'h0},
    '{3'b111, 32'h400,  32'd4,  12'h004, 12'h004, 3'b000, 32'h0,    32'h0,    32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; dec_req = 0; stall = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    op_valid = 1;
    for (int i = 0; i < 8; i++) begin
      op_func = VECS[i].f; op_pc = VECS[i].pc; op_rs1 = VECS[i].rs1;
      op_imm_i = VECS[i].ii; op_imm_z = VECS[i].iz;
      #1;
      chk($sformatf("R4-R8 vec%0d we", i), {29'd0, dec_we}, {29'd0, VECS[i].we});
      if (VECS[i].we[0]) chk($sformatf("R4 R6 R7 vec%0d start", i), dec_start, VECS[i].s);
      if (VECS[i].we[1]) chk($sformatf("R4 R6 R7 vec%0d end", i), dec_end, VECS[i].e);
      if (VECS[i].we[2]) chk($sformatf("R5 R6 R7 vec%0d cnt", i), dec_cnt, VECS[i].c);
    end
    op_func = 3'b100; op_valid = 0; #1;
    chk("R8 invalid op", {29'd0, dec_we}, 32'd0);

    // R1 reset
    #5 @(negedge clk);
    chk("R1 start", rd_start[31:0], 0);
    chk("R1 cnt", rd_cnt[63:32], 0);
    rst_n = 1;
    @(negedge clk);

    // R2 all three to set 1
    wr_en = 3'b111; wr_set = 1; wr_start = 32'hA0; wr_end = 32'hB0; wr_cnt = 3;
    step();
    chk("R2 set1 start", rd_start[63:32], 32'hA0);
    chk("R2 set1 end", rd_end[63:32], 32'hB0);
    chk("R2 set1 cnt", rd_cnt[63:32], 3);
    chk("R2 set0 untouched", rd_start[31:0], 0);

    // R2 start only on set 0
    wr_en = 3'b001; wr_set = 0; wr_start = 32'hC0; wr_end = 32'hDD; wr_cnt = 32'hEE;
    step();
    chk("R2 set0 start", rd_start[31:0], 32'hC0);
    chk("R2 set0 end kept", rd_end[31:0], 0);
    chk("R2 set0 cnt kept", rd_cnt[31:0], 0);

    // R3 out-of-range index
    wr_en = 3'b111; wr_set = 3; wr_start = 32'h1; wr_end = 32'h2; wr_cnt = 32'h3;
    step();
    chk("R3 set0 start", rd_start[31:0], 32'hC0);
    chk("R3 set1 end", rd_end[63:32], 32'hB0);
    chk("R3 set1 cnt", rd_cnt[63:32], 3);

    // R9 decrement
    dec_req = 1; dec_sel = 1;
    step();
    chk("R9 dec set1", rd_cnt[63:32], 2);

    // R10 stall blocks
    dec_req = 1; dec_sel = 1; stall = 1;
    step();
    chk("R10 stalled", rd_cnt[63:32], 2);

    // R11 write wins
    dec_req = 1; dec_sel = 1; wr_en = 3'b100; wr_set = 1; wr_cnt = 32'd10;
    step();
    chk("R11 write wins", rd_cnt[63:32], 10);

    // R9 wrap on set 0 while writing set 1
    dec_req = 1; dec_sel = 0; wr_en = 3'b100; wr_set = 1; wr_cnt = 32'd20;
    step();
    chk("R9 wrap set0", rd_cnt[31:0], 32'hFFFFFFFF);
    chk("R2 set1 cnt parallel", rd_cnt[63:32], 20);

    // R1 reset clears again
    rst_n = 0; #1;
    chk("R1 async clear", rd_cnt[63:32], 0);
    chk("R1 async clear start", rd_start[31:0], 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule